// File: doc/BRIEF.md
# ADC Step Sequencer

This block drives an analog-to-digital converter through a short programmed list of conversions. Software loads a 32-bit control word with one 4-bit field per step, up to eight steps, and a 32-bit selection word with one 4-bit input number per step. A trigger pulse starts a run at step 0. For each step the block issues a one-cycle conversion request that carries the analog input or input pair. It waits for the converter's completion pulse and then presents the result, tagged with its step number, on a one-cycle push output for downstream storage.

Each step field has four bits. Bit 0 selects differential sampling. Bit 1 marks the step as the last one. Bit 2 enables the interrupt. Bit 3 is reserved. A run stops after the first step that carries the last-step mark. Any step whose interrupt bit is set raises a sticky raw interrupt flag when its conversion completes. A separate mask input gates that flag onto the interrupt output.

The controller is a four-state machine. IDLE waits for a trigger (transition *start*). REQUEST drives the request for one cycle (transition *issue*). WAIT holds until the converter reports completion (transition *complete*). PUSH presents the result and then either returns to REQUEST with the next step (transition *advance*) or goes back to IDLE (transition *finish*). Converter completion pulses outside WAIT are ignored. A build-time option turns the block into a single-step sequencer.

Top module: `adc_step_sequencer`

## Requirements
- R1: The control word is held as eight 4-bit fields. Step n occupies bits [4n+3:4n]: bit 4n is the differential select, bit 4n+1 the last-step mark, bit 4n+2 the interrupt enable, and bit 4n+3 is reserved and always reads back as 0 on `cfg_ctl_rdata`.
- R2: After reset the control word reads 0, both interrupt outputs are 0, and no request or push is active.
- R3: The step whose last-step mark is set is the final step converted. No request is issued for any later step, whatever its field holds, and the flags of those later steps have no effect.
- R4: A run may end at any step position, from step 0 to step 7. A run ending at step k issues exactly k+1 requests, and the steps are pushed in order 0..k.
- R5: If no step carries a last-step mark, the run ends after step 7, with exactly eight requests.
- R6: When the conversion of a step with its interrupt enable set completes, the raw flag `irq_raw` is set on the clock edge that ends that step's push cycle. Steps without the enable leave the flag unchanged.
- R7: Several steps within one run can each set the raw flag, once per enabled step.
- R8: `irq` is 1 exactly when `irq_raw` is 1 and `irq_mask_en` is 1.
- R9: For a differential step with input number i, the request drives `conv_diff`=1, `conv_pos`=2i and `conv_neg`=2i+1. For a single-ended step it drives `conv_diff`=0, `conv_pos`=i and `conv_neg`=0.
- R10: With `SINGLE_STEP`=1, step 0's last-step mark is treated as set, and reads back as set, whatever value was written. Every run is then one conversion.
- R11: A trigger that arrives while a run is in progress is ignored. Every run starts from step 0.
- R12: `irq_raw` stays set until a one-cycle `irq_clear` pulse clears it. If a clear and a set fall on the same edge, the flag ends up set.
- R13: Each completion in WAIT produces exactly one one-cycle push. The push carries the converter's result on `push_data` and the step number on `push_step`. Each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctl_we | input | 1 | Write strobe for the control word |
| cfg_ctl_wdata | input | 32 | Control word write data (eight 4-bit step fields) |
| cfg_sel_we | input | 1 | Write strobe for the input selection word |
| cfg_sel_wdata | input | 32 | Input number per step, 4 bits each, step n at [4n+3:4n] |
| cfg_ctl_rdata | output | 32 | Control word as held, reserved bits zero |
| irq_mask_en | input | 1 | Gates the raw flag onto `irq` |
| irq_clear | input | 1 | Clear pulse for the raw flag |
| trigger | input | 1 | Starts a run when idle |
| conv_req | output | 1 | One-cycle conversion request |
| conv_diff | output | 1 | Request is a differential pair |
| conv_pos | output | 5 | Positive (or sole) analog input number |
| conv_neg | output | 5 | Negative input number of a pair, 0 otherwise |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| push_valid | output | 1 | One-cycle result push |
| push_data | output | 12 | Result being pushed |
| push_step | output | 3 | Step number of the pushed result |
| irq_raw | output | 1 | Sticky raw interrupt flag |
| irq | output | 1 | Masked interrupt |

## Verification
The raw-flag set from an interrupt-enabled step and the clear pulse from software can land on the same clock edge. The bench provokes this by holding `irq_clear` high for exactly the push cycle of a one-step run whose step has its interrupt enable set. It judges the outcome by reading `irq_raw` as 1 afterwards, and by then showing that the flag stays set with no clear and drops after one lone clear pulse. Elsewhere the bench clears the flag automatically after each rise, so that it can count separate interrupting steps within a single run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_REQUEST = 2'd1,
        SEQ_WAIT    = 2'd2,
        SEQ_PUSH    = 2'd3
    } seq_state_t;

    // One step field; packed order puts the reserved bit at the top.
    typedef struct packed {
        logic rsvd;
        logic irq_en;
        logic last;
        logic diff;
    } step_cfg_t;

endpackage

// File: rtl/seqr_cfg_store.sv
module seqr_cfg_store
    import adc_seq_pkg::*;
#(
    parameter int N_STEPS     = 8,
    parameter int SEL_W       = 4,
    parameter int SINGLE_STEP = 0,
    parameter int CTL_W       = N_STEPS * FIELD_W,
    parameter int SEL_TOT     = N_STEPS * SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               sel_we,
    input  logic [SEL_TOT-1:0] sel_wdata,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [SEL_TOT-1:0] sel_q
);

    genvar g;
    generate
        for (g = 0; g < N_STEPS; g++) begin : g_step
            localparam bit FORCE_LAST = (SINGLE_STEP != 0) && (g == 0);
            step_cfg_t wr_f;
            step_cfg_t rd_f;
            logic [2:0] bits_q;
            logic       unused_wr_rsvd;

            assign wr_f           = ctl_wdata[g*FIELD_W +: FIELD_W];
            assign unused_wr_rsvd = wr_f.rsvd;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits_q <= '0;
                end else if (ctl_we) begin
                    bits_q <= {wr_f.irq_en, wr_f.last, wr_f.diff};
                end
            end

            always_comb begin
                rd_f.rsvd   = 1'b0;
                rd_f.irq_en = bits_q[2];
                rd_f.last   = bits_q[1] | FORCE_LAST;
                rd_f.diff   = bits_q[0];
            end

            assign ctl_q[g*FIELD_W +: FIELD_W] = rd_f;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

endmodule

// File: rtl/seqr_step_view.sv
module seqr_step_view
    import adc_seq_pkg::*;
#(
    parameter int N_STEPS = 8,
    parameter int SEL_W   = 4,
    parameter int STEP_W  = 3,
    parameter int CH_W    = SEL_W + 1,
    parameter int CTL_W   = N_STEPS * FIELD_W,
    parameter int SEL_TOT = N_STEPS * SEL_W
) (
    input  logic [STEP_W-1:0]  step_idx,
    input  logic [CTL_W-1:0]   ctl_q,
    input  logic [SEL_TOT-1:0] sel_q,
    output logic               cur_irq_en,
    output logic               cur_last,
    output logic               cur_diff,
    output logic [CH_W-1:0]    ch_pos,
    output logic [CH_W-1:0]    ch_neg
);

    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(N_STEPS - 1);

    logic             f_ie   [N_STEPS];
    logic             f_last [N_STEPS];
    logic             f_diff [N_STEPS];
    logic [SEL_W-1:0] f_sel  [N_STEPS];
    logic [N_STEPS-1:0] unused_rsvd;

    genvar g;
    generate
        for (g = 0; g < N_STEPS; g++) begin : g_unpack
            step_cfg_t fld;
            assign fld            = ctl_q[g*FIELD_W +: FIELD_W];
            assign f_ie[g]        = fld.irq_en;
            assign f_last[g]      = fld.last;
            assign f_diff[g]      = fld.diff;
            assign unused_rsvd[g] = fld.rsvd;
            assign f_sel[g]       = sel_q[g*SEL_W +: SEL_W];
        end
    endgenerate

    always_comb begin
        cur_irq_en = f_ie[step_idx];
        cur_diff   = f_diff[step_idx];
        // The final slot always ends the run so a missing mark cannot loop.
        cur_last   = f_last[step_idx] || (step_idx == LAST_IDX);
        if (cur_diff) begin
            ch_pos = {f_sel[step_idx], 1'b0};
            ch_neg = {f_sel[step_idx], 1'b1};
        end else begin
            ch_pos = {1'b0, f_sel[step_idx]};
            ch_neg = '0;
        end
    end

endmodule

// File: rtl/seqr_irq_flag.sv
module seqr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    input  logic mask_en,
    output logic raw,
    output logic masked
);

    logic raw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (set_pulse) begin
            raw_q <= 1'b1;
        end else if (clr_pulse) begin
            raw_q <= 1'b0;
        end
    end

    assign raw    = raw_q;
    assign masked = raw_q & mask_en;

endmodule

// File: rtl/seqr_ctrl_fsm.sv
module seqr_ctrl_fsm
    import adc_seq_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              cur_last,
    input  logic              cur_irq_en,
    output logic [STEP_W-1:0] step_idx,
    output logic              conv_req,
    output logic              push_valid,
    output logic [RES_W-1:0]  push_data,
    output logic              irq_set
);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [RES_W-1:0]  res_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (trigger)   state_d = SEQ_REQUEST;   // start
            SEQ_REQUEST:                state_d = SEQ_WAIT;      // issue
            SEQ_WAIT:    if (conv_done) state_d = SEQ_PUSH;      // complete
            SEQ_PUSH:    state_d = cur_last ? SEQ_IDLE           // finish
                                            : SEQ_REQUEST;       // advance
            default:                    state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Step counter and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            res_q  <= '0;
        end else begin
            if (state_q == SEQ_IDLE && trigger) begin
                step_q <= '0;
            end else if (state_q == SEQ_PUSH && !cur_last) begin
                step_q <= step_q + 1'b1;
            end
            if (state_q == SEQ_WAIT && conv_done) begin
                res_q <= conv_result;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        conv_req   = 1'b0;
        push_valid = 1'b0;
        irq_set    = 1'b0;
        unique case (state_q)
            SEQ_IDLE:    ;
            SEQ_REQUEST: conv_req = 1'b1;
            SEQ_WAIT:    ;
            SEQ_PUSH: begin
                push_valid = 1'b1;
                irq_set    = cur_irq_en;
            end
            default:     ;
        endcase
    end

    assign step_idx  = step_q;
    assign push_data = res_q;

endmodule

// File: rtl/adc_step_sequencer.sv
module adc_step_sequencer
    import adc_seq_pkg::*;
#(
    parameter int N_STEPS     = 8,
    parameter int SEL_W       = 4,
    parameter int RES_W       = 12,
    parameter int SINGLE_STEP = 0,
    parameter int CTL_W       = N_STEPS * FIELD_W,
    parameter int SEL_TOT     = N_STEPS * SEL_W,
    parameter int CH_W        = SEL_W + 1,
    parameter int STEP_W      = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_ctl_we,
    input  logic [CTL_W-1:0]   cfg_ctl_wdata,
    input  logic               cfg_sel_we,
    input  logic [SEL_TOT-1:0] cfg_sel_wdata,
    output logic [CTL_W-1:0]   cfg_ctl_rdata,
    input  logic               irq_mask_en,
    input  logic               irq_clear,
    input  logic               trigger,
    output logic               conv_req,
    output logic               conv_diff,
    output logic [CH_W-1:0]    conv_pos,
    output logic [CH_W-1:0]    conv_neg,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    output logic               push_valid,
    output logic [RES_W-1:0]   push_data,
    output logic [STEP_W-1:0]  push_step,
    output logic               irq_raw,
    output logic               irq
);

    logic [CTL_W-1:0]   ctl_q;
    logic [SEL_TOT-1:0] sel_q;
    logic [STEP_W-1:0]  step_idx;
    logic               cur_irq_en;
    logic               cur_last;
    logic               irq_set;

    seqr_cfg_store #(
        .N_STEPS(N_STEPS), .SEL_W(SEL_W), .SINGLE_STEP(SINGLE_STEP),
        .CTL_W(CTL_W), .SEL_TOT(SEL_TOT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(cfg_ctl_we), .ctl_wdata(cfg_ctl_wdata),
        .sel_we(cfg_sel_we), .sel_wdata(cfg_sel_wdata),
        .ctl_q(ctl_q), .sel_q(sel_q)
    );

    seqr_step_view #(
        .N_STEPS(N_STEPS), .SEL_W(SEL_W), .STEP_W(STEP_W), .CH_W(CH_W),
        .CTL_W(CTL_W), .SEL_TOT(SEL_TOT)
    ) u_view (
        .step_idx(step_idx), .ctl_q(ctl_q), .sel_q(sel_q),
        .cur_irq_en(cur_irq_en), .cur_last(cur_last), .cur_diff(conv_diff),
        .ch_pos(conv_pos), .ch_neg(conv_neg)
    );

    seqr_ctrl_fsm #(
        .STEP_W(STEP_W), .RES_W(RES_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .trigger(trigger),
        .conv_done(conv_done), .conv_result(conv_result),
        .cur_last(cur_last), .cur_irq_en(cur_irq_en),
        .step_idx(step_idx), .conv_req(conv_req),
        .push_valid(push_valid), .push_data(push_data), .irq_set(irq_set)
    );

    seqr_irq_flag u_irq (
        .clk(clk), .rst_n(rst_n), .set_pulse(irq_set), .clr_pulse(irq_clear),
        .mask_en(irq_mask_en), .raw(irq_raw), .masked(irq)
    );

    assign cfg_ctl_rdata = ctl_q;
    assign push_step     = step_idx;

endmodule

// File: rtl/adc_step_sequencer_chk.sv
module adc_step_sequencer_chk #(
    parameter int N_STEPS     = 8,
    parameter int SINGLE_STEP = 0,
    parameter int CTL_W       = 32,
    parameter int CH_W        = 5,
    parameter int STEP_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTL_W-1:0]  cfg_ctl_rdata,
    input logic              irq_mask_en,
    input logic              irq_clear,
    input logic              conv_req,
    input logic              conv_diff,
    input logic [CH_W-1:0]   conv_pos,
    input logic [CH_W-1:0]   conv_neg,
    input logic              push_valid,
    input logic [STEP_W-1:0] push_step,
    input logic              irq_raw,
    input logic              irq
);

    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(N_STEPS - 1);

    logic push_marked;
    assign push_marked = cfg_ctl_rdata[int'(push_step) * 4 + 1];

    assert_req_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    assert_push_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);

    assert_stop_at_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_marked) |=> !conv_req);

    assert_continue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_marked && push_step != LAST_IDX) |=> conv_req);

    assert_cap_eight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_step == LAST_IDX) |=> !conv_req);

    assert_rise_on_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> $past(push_valid));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !irq_clear) |=> irq_raw);

    assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask_en |-> !irq);

    assert_mask_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_raw);

    assert_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_diff) |-> (!conv_pos[0] && conv_neg == conv_pos + 1'b1));

    assert_single_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_diff) |-> (conv_neg == '0));

    generate
        if (SINGLE_STEP != 0) begin : g_single
            assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
                push_valid |=> !conv_req);
        end
    endgenerate

endmodule

bind adc_step_sequencer adc_step_sequencer_chk #(
    .N_STEPS(N_STEPS), .SINGLE_STEP(SINGLE_STEP), .CTL_W(CTL_W),
    .CH_W(CH_W), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_ctl_rdata(cfg_ctl_rdata),
    .irq_mask_en(irq_mask_en), .irq_clear(irq_clear),
    .conv_req(conv_req), .conv_diff(conv_diff),
    .conv_pos(conv_pos), .conv_neg(conv_neg),
    .push_valid(push_valid), .push_step(push_step),
    .irq_raw(irq_raw), .irq(irq)
);

// File: tb/adc_step_sequencer_bench.sv
`timescale 1ns/1ps
module adc_step_sequencer_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        cfg_ctl_we, cfg_sel_we;
    logic [31:0] cfg_ctl_wdata, cfg_sel_wdata, cfg_ctl_rdata;
    logic        irq_mask_en, irq_clear, trigger;
    logic        conv_req, conv_diff, conv_done;
    logic [4:0]  conv_pos, conv_neg;
    logic [11:0] conv_result, push_data;
    logic        push_valid, irq_raw, irq;
    logic [2:0]  push_step;

    logic        s_ctl_we, s_trigger, s_conv_req, s_conv_diff, s_conv_done;
    logic [31:0] s_ctl_wdata, s_ctl_rdata;
    logic [4:0]  s_conv_pos, s_conv_neg;
    logic [11:0] s_conv_result, s_push_data;
    logic        s_push_valid, s_irq_raw, s_irq;
    logic [2:0]  s_push_step;

    adc_step_sequencer u_adc_step_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_ctl_we(cfg_ctl_we), .cfg_ctl_wdata(cfg_ctl_wdata),
        .cfg_sel_we(cfg_sel_we), .cfg_sel_wdata(cfg_sel_wdata),
        .cfg_ctl_rdata(cfg_ctl_rdata), .irq_mask_en(irq_mask_en),
        .irq_clear(irq_clear), .trigger(trigger),
        .conv_req(conv_req), .conv_diff(conv_diff),
        .conv_pos(conv_pos), .conv_neg(conv_neg),
        .conv_done(conv_done), .conv_result(conv_result),
        .push_valid(push_valid), .push_data(push_data), .push_step(push_step),
        .irq_raw(irq_raw), .irq(irq)
    );

    adc_step_sequencer #(.SINGLE_STEP(1)) u_adc_step_sequencer_single (
        .clk(clk), .rst_n(rst_n),
        .cfg_ctl_we(s_ctl_we), .cfg_ctl_wdata(s_ctl_wdata),
        .cfg_sel_we(1'b0), .cfg_sel_wdata(32'h0),
        .cfg_ctl_rdata(s_ctl_rdata), .irq_mask_en(1'b0),
        .irq_clear(1'b0), .trigger(s_trigger),
        .conv_req(s_conv_req), .conv_diff(s_conv_diff),
        .conv_pos(s_conv_pos), .conv_neg(s_conv_neg),
        .conv_done(s_conv_done), .conv_result(s_conv_result),
        .push_valid(s_push_valid), .push_data(s_push_data), .push_step(s_push_step),
        .irq_raw(s_irq_raw), .irq(s_irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          n_push, n_req, rises, s_n_push, s_n_req;
    int          push_steps [32];
    logic [11:0] push_vals  [32];
    int          clr_mode;
    bit          clr_once;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [31:0] c);
        for (int i = 0; i < 8; i++) if (c[4*i+1]) return i + 1;
        return 8;
    endfunction

    // Converter model for the main instance: fixed latency, result encodes the inputs.
    initial begin
        conv_done = 1'b0; conv_result = '0;
        forever begin
            @(negedge clk);
            if (conv_req === 1'b1) begin
                logic [11:0] r;
                r = {1'b0, conv_diff, conv_pos, conv_neg};
                n_req++;
                repeat (2) @(negedge clk);
                conv_result = r; conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    initial begin
        s_conv_done = 1'b0; s_conv_result = '0;
        forever begin
            @(negedge clk);
            if (s_conv_req === 1'b1) begin
                s_n_req++;
                repeat (2) @(negedge clk);
                s_conv_result = 12'h5A5; s_conv_done = 1'b1;
                @(negedge clk);
                s_conv_done = 1'b0;
            end
        end
    end

    // Push logger and clear-pulse driver.
    initial begin
        irq_clear = 1'b0;
        forever begin
            @(negedge clk);
            if (push_valid === 1'b1) begin
                if (n_push < 32) begin
                    push_steps[n_push] = int'(push_step);
                    push_vals[n_push]  = push_data;
                end
                n_push++;
            end
            if (s_push_valid === 1'b1) s_n_push++;
            if (clr_mode == 1 && irq_raw && !irq_clear) begin
                rises++; irq_clear = 1'b1;
            end else if (clr_mode == 2 && push_valid) begin
                irq_clear = 1'b1;
            end else if (clr_once) begin
                irq_clear = 1'b1; clr_once = 1'b0;
            end else begin
                irq_clear = 1'b0;
            end
        end
    end

    task automatic write_ctl(input logic [31:0] v);
        @(negedge clk); cfg_ctl_wdata = v; cfg_ctl_we = 1'b1;
        @(negedge clk); cfg_ctl_we = 1'b0;
    endtask

    task automatic write_sel(input logic [31:0] v);
        @(negedge clk); cfg_sel_wdata = v; cfg_sel_we = 1'b1;
        @(negedge clk); cfg_sel_we = 1'b0;
    endtask

    task automatic clear_logs();
        n_push = 0; n_req = 0; rises = 0;
    endtask

    task automatic pulse_trigger();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic run_main();
        clear_logs();
        pulse_trigger();
        repeat (80) @(negedge clk);
    endtask

    task automatic do_clear();
        clr_once = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cfg_ctl_rdata == 32'h0, "R2 ctl after reset", cfg_ctl_rdata, 0);
        chk(irq_raw == 1'b0 && irq == 1'b0, "R2 irq after reset", {irq_raw, irq}, 0);
        chk(conv_req == 1'b0 && push_valid == 1'b0, "R2 idle after reset", {conv_req, push_valid}, 0);
    endtask

    task automatic t_layout();
        write_ctl(32'hFFFF_FFFF);
        chk(cfg_ctl_rdata == 32'h7777_7777, "R1 reserved bits read zero", cfg_ctl_rdata, 32'h7777_7777);
    endtask

    task automatic t_end_positions();
        int ends [3] = '{0, 3, 7};
        foreach (ends[k]) begin
            logic [31:0] c;
            int e;
            e = ends[k];
            c = '0;
            for (int i = 0; i < 8; i++) begin
                if (i < e)       c[4*i +: 4] = 4'h1;
                else if (i == e) c[4*i +: 4] = 4'h2;
                else             c[4*i +: 4] = 4'h7;
            end
            write_ctl(c);
            run_main();
            chk(n_req == exp_len(c), "R3 request count at end mark", n_req, exp_len(c));
            chk(n_push == e + 1, "R4 push count for end position", n_push, e + 1);
            chk(push_steps[n_push-1] == e, "R4 final pushed step", push_steps[n_push-1], e);
            for (int i = 0; i < e + 1; i++)
                chk(push_steps[i] == i, "R4 step order", push_steps[i], i);
            chk(irq_raw == 1'b0, "R3 flags after end mark ignored", irq_raw, 0);
        end
    endtask

    task automatic t_no_end();
        write_ctl(32'h1111_1111);
        run_main();
        chk(n_req == 8, "R5 eight requests without mark", n_req, 8);
        chk(n_push == 8 && push_steps[7] == 7, "R5 eight pushes", n_push, 8);
    endtask

    task automatic t_diff();
        write_sel(32'h0000_0F53);
        write_ctl(32'h0000_0301);
        run_main();
        chk(n_push == 3, "R13 push count", n_push, 3);
        chk(push_vals[0] == 12'd1223, "R9 pair 3 -> inputs 6,7", push_vals[0], 1223);
        chk(push_vals[1] == 12'd160, "R9 single-ended input 5", push_vals[1], 160);
        chk(push_vals[2] == 12'd2015, "R9 pair 15 -> inputs 30,31", push_vals[2], 2015);
        chk(push_steps[1] == 1, "R13 push step tag", push_steps[1], 1);
        write_sel(32'h0);
    endtask

    task automatic t_irq();
        irq_mask_en = 1'b0;
        write_ctl(32'h0000_2400);
        run_main();
        chk(irq_raw == 1'b1, "R6 enabled step sets flag", irq_raw, 1);
        chk(irq == 1'b0, "R8 masked off", irq, 0);
        @(negedge clk); irq_mask_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 mask on", irq, 1);
        irq_mask_en = 1'b0;
        do_clear();
        chk(irq_raw == 1'b0, "R12 clear pulse", irq_raw, 0);
        write_ctl(32'h0000_2000);
        run_main();
        chk(irq_raw == 1'b0, "R6 steps without enable leave flag", irq_raw, 0);
        clr_mode = 1;
        write_ctl(32'h0240_0404);
        run_main();
        chk(rises == 3, "R7 three interrupting steps", rises, 3);
        chk(n_push == 7, "R7 run length", n_push, 7);
        clr_mode = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collide();
        clr_mode = 2;
        write_ctl(32'h0000_0006);
        run_main();
        clr_mode = 0;
        chk(irq_raw == 1'b1, "R12 set wins over same-cycle clear", irq_raw, 1);
        repeat (5) @(negedge clk);
        chk(irq_raw == 1'b1, "R12 flag holds", irq_raw, 1);
        do_clear();
        chk(irq_raw == 1'b0, "R12 lone clear", irq_raw, 0);
    endtask

    task automatic t_retrigger();
        write_ctl(32'h0002_0000);
        clear_logs();
        pulse_trigger();
        repeat (10) @(negedge clk);
        pulse_trigger();
        repeat (80) @(negedge clk);
        chk(n_push == 5, "R11 trigger during run ignored", n_push, 5);
        chk(push_steps[0] == 0 && push_steps[4] == 4, "R11 order", push_steps[4], 4);
        run_main();
        chk(n_push == 5 && push_steps[0] == 0, "R11 new run from step 0", push_steps[0], 0);
    endtask

    task automatic t_single();
        @(negedge clk); s_ctl_wdata = 32'h4444_4444; s_ctl_we = 1'b1;
        @(negedge clk); s_ctl_we = 1'b0;
        chk(s_ctl_rdata == 32'h4444_4446, "R10 step 0 end forced", s_ctl_rdata, 32'h4444_4446);
        s_n_push = 0; s_n_req = 0;
        @(negedge clk); s_trigger = 1'b1;
        @(negedge clk); s_trigger = 1'b0;
        repeat (40) @(negedge clk);
        chk(s_n_req == 1 && s_n_push == 1, "R10 single conversion", s_n_push, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_ctl_we = 1'b0; cfg_sel_we = 1'b0; cfg_ctl_wdata = '0; cfg_sel_wdata = '0;
        irq_mask_en = 1'b0; trigger = 1'b0;
        s_ctl_we = 1'b0; s_ctl_wdata = '0; s_trigger = 1'b0;
        clr_mode = 0; clr_once = 1'b0;
        n_push = 0; n_req = 0; rises = 0; s_n_push = 0; s_n_req = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_end_positions();
        t_no_end();
        t_diff();
        t_irq();
        t_collide();
        t_retrigger();
        t_single();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule